// File: doc/BRIEF.md
# Two-Channel Up/Down Pulse Counter

This block counts edges from two independent input channels into one signed accumulator. Each channel pairs a pulse line with a control line. For each channel, software sets what a rising edge and what a falling edge of the pulse line do to the count. It also sets how the current level of the control line modifies that action: the action can stand, be reversed, or be suppressed. With suitable settings, one unit can decode a two-phase quadrature encoder or a step/direction pair.

All four input lines pass through a synchronizer chain. Each line then passes through an optional persistence filter, which rejects any pulse shorter than a programmed number of clock cycles. Edges are detected on the filtered levels.

Software reaches the block through a small synchronous port with four word addresses. A write takes effect at the next clock edge. A read is combinational from the address. Software can hold the count frozen or force it to zero.

Top module: `quad_pulse_counter`

## Requirements
- R1: After reset, the count and all configuration words (mode at address 0, control at address 1, filter threshold at address 2) read back as zero.
- R2: A write to addresses 0, 1 or 2 is read back unchanged in the implemented bits: all 16 bits at address 0, bits 2:0 at address 1, and bits FLT_W-1:0 at address 2. A write to address 3 has no effect on the count.
- R3: The mode word at address 0 holds channel 0 in bits 7:0 and channel 1 in bits 15:8. Within a channel byte, bits 1:0 set the rising-edge action and bits 3:2 set the falling-edge action. The action codes are 0 no change, 1 add one, 2 subtract one, and 3 no change.
- R4: Within a channel byte, bits 5:4 give the control code used while the filtered control line is high, and bits 7:6 give the code used while it is low. The control codes are 0 keep the edge action, 1 swap add and subtract, 2 suppress, and 3 suppress.
- R5: When both channels produce a change on the same clock, the count moves by their sum (+2, 0 or -2) in that one clock.
- R6: While control bit 0 (hold) is set, the count does not change and edges that arrive are discarded. After the bit is cleared, counting continues from the held value.
- R7: While control bit 1 (zero) is set, the count reads zero whatever the inputs do. After the bit is cleared, counting restarts from zero.
- R8: With control bit 2 (filter enable) set and threshold T at address 2, a filtered level follows its input only after the input has differed from it for T consecutive cycles, so pulses shorter than T cycles are not counted. With the bit clear, every level change passes.
- R9: The count is a CNT_W-bit two's-complement value that wraps from the most positive value to the most negative value and back. Address 3 returns it sign-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Word address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the word at addr |
| pulse_in | input | 2 | Pulse lines, bit n belongs to channel n |
| ctrl_in | input | 2 | Control lines, bit n belongs to channel n |

## Verification
The bench builds the counter with CNT_W set to 6, so the count spans -32 to 31. This puts both directions of the two's-complement wrap within a few dozen pulses. FLT_W stays at its default of 10, which lets the bench check the full threshold field on readback, while a threshold of 5 separates a 4-cycle glitch from a 5-cycle pulse. SYNC_N stays at 2, so each input change reaches the count a fixed four clocks later when filtering is off.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_INC  = 2'd1,
      EDGE_DEC  = 2'd2,
      EDGE_RSV  = 2'd3
   } edge_act_e;

   typedef enum logic [1:0] {
      CTL_KEEP  = 2'd0,
      CTL_SWAP  = 2'd1,
      CTL_MUTE  = 2'd2,
      CTL_MUTE2 = 2'd3
   } ctl_act_e;

   typedef struct packed {
      ctl_act_e  on_low;
      ctl_act_e  on_high;
      edge_act_e on_fall;
      edge_act_e on_rise;
   } chan_cfg_t;

   localparam int REG_W    = 16;
   localparam int NUM_CH   = 2;
   localparam logic [1:0] A_MODE  = 2'd0;
   localparam logic [1:0] A_CTRL  = 2'd1;
   localparam logic [1:0] A_THR   = 2'd2;
   localparam logic [1:0] A_COUNT = 2'd3;

endpackage

// File: rtl/qpc_filter.sv
module qpc_filter #(
   parameter int FLT_W  = 10,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_in,
   input  logic             flt_en,
   input  logic [FLT_W-1:0] flt_thr,
   output logic             sync_o,
   output logic             lvl_o
);
   localparam int RUN_W = FLT_W + 1;

   logic [SYNC_N-1:0] chain;
   logic [FLT_W-1:0]  run;
   logic              lvl;
   logic              sync_lvl;
   logic [RUN_W-1:0]  run_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_N-2:0], raw_in};
   end

   assign sync_lvl = chain[SYNC_N-1];
   assign run_next = {1'b0, run} + RUN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= '0;
         lvl <= 1'b0;
      end else if (!flt_en) begin
         run <= '0;
         lvl <= sync_lvl;
      end else if (sync_lvl == lvl) begin
         run <= '0;
      end else if (run_next >= {1'b0, flt_thr}) begin
         run <= '0;
         lvl <= sync_lvl;
      end else begin
         run <= run_next[FLT_W-1:0];
      end
   end

   assign sync_o = sync_lvl;
   assign lvl_o  = lvl;
endmodule

// File: rtl/qpc_chan.sv
module qpc_chan
   import qpc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pulse_lvl,
   input  logic              ctrl_lvl,
   input  chan_cfg_t         cfg,
   output logic signed [1:0] delta
);
   logic      prev;
   logic      rise;
   logic      fall;
   edge_act_e act;
   ctl_act_e  mod;
   logic signed [1:0] base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= pulse_lvl;
   end

   assign rise = pulse_lvl & ~prev;
   assign fall = ~pulse_lvl & prev;

   always_comb begin
      if (rise)      act = cfg.on_rise;
      else if (fall) act = cfg.on_fall;
      else           act = EDGE_NONE;
      mod = ctrl_lvl ? cfg.on_high : cfg.on_low;
      case (act)
         EDGE_INC: base = 2'sd1;
         EDGE_DEC: base = -2'sd1;
         default:  base = 2'sd0;
      endcase
      case (mod)
         CTL_KEEP: delta = base;
         CTL_SWAP: delta = -base;
         default:  delta = 2'sd0;
      endcase
   end
endmodule

// File: rtl/quad_pulse_counter.sv
module quad_pulse_counter
   import qpc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int FLT_W  = 10,
   parameter int SYNC_N = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  addr,
   input  logic [15:0] wdata,
   output logic [15:0] rdata,
   input  logic [1:0]  pulse_in,
   input  logic [1:0]  ctrl_in
);
   localparam int NUM_IN = 2 * NUM_CH;
   localparam int SUM_W  = 3;

   if (CNT_W < 4 || CNT_W > REG_W) begin : g_bad_cnt
      $error("quad_pulse_counter: CNT_W must lie in 4..16");
   end
   if (FLT_W < 1 || FLT_W > REG_W) begin : g_bad_flt
      $error("quad_pulse_counter: FLT_W must lie in 1..16");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("quad_pulse_counter: SYNC_N must be at least 2");
   end

   logic [REG_W-1:0]   mode_q;
   logic               hold_q;
   logic               zero_q;
   logic               fen_q;
   logic [FLT_W-1:0]   thr_q;
   logic [CNT_W-1:0]   count_q;
   logic [NUM_IN-1:0]  raw_lvl;
   logic [NUM_IN-1:0]  sync_lvl;
   logic [NUM_IN-1:0]  filt_lvl;
   logic signed [1:0]  ch_delta [NUM_CH];
   logic signed [SUM_W-1:0] step;
   logic [CNT_W-1:0]   step_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         hold_q <= 1'b0;
         zero_q <= 1'b0;
         fen_q  <= 1'b0;
         thr_q  <= '0;
      end else if (wr_en) begin
         case (addr)
            A_MODE: mode_q <= wdata;
            A_CTRL: {fen_q, zero_q, hold_q} <= wdata[2:0];
            A_THR:  thr_q <= wdata[FLT_W-1:0];
            default: ;
         endcase
      end
   end

   assign raw_lvl = {ctrl_in, pulse_in};

   for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      qpc_filter #(.FLT_W(FLT_W), .SYNC_N(SYNC_N)) u_flt (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_in  (raw_lvl[i]),
         .flt_en  (fen_q),
         .flt_thr (thr_q),
         .sync_o  (sync_lvl[i]),
         .lvl_o   (filt_lvl[i])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      qpc_chan u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .pulse_lvl (filt_lvl[c]),
         .ctrl_lvl  (filt_lvl[NUM_CH + c]),
         .cfg       (chan_cfg_t'(mode_q[8*c +: 8])),
         .delta     (ch_delta[c])
      );
   end

   assign step     = SUM_W'(ch_delta[0]) + SUM_W'(ch_delta[1]);
   assign step_ext = {{(CNT_W-SUM_W){step[SUM_W-1]}}, step};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count_q <= '0;
      else if (zero_q) count_q <= '0;
      else if (!hold_q) count_q <= count_q + step_ext;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_MODE: rdata = mode_q;
         A_CTRL: rdata[2:0] = {fen_q, zero_q, hold_q};
         A_THR:  rdata[FLT_W-1:0] = thr_q;
         default: begin
            rdata = {REG_W{count_q[CNT_W-1]}};
            rdata[CNT_W-1:0] = count_q;
         end
      endcase
   end
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [15:0]      mode_q,
   input logic             hold_q,
   input logic             zero_q,
   input logic [CNT_W-1:0] count_q,
   input logic [3:0]       sync_lvl,
   input logic [3:0]       filt_lvl
);
   logic [CNT_W-1:0]        cnt_prev;
   logic signed [CNT_W-1:0] moved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_prev <= '0;
      else        cnt_prev <= count_q;
   end

   assign moved = $signed(count_q - cnt_prev);

   // R7
   zero_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_q |=> (count_q == '0));

   // R6
   hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !zero_q) |=> $stable(count_q));

   // R5
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_q && !zero_q) |=> (moved >= -2 && moved <= 2));

   // R2
   mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == 2'd0) |=> $stable(mode_q));

   for (genvar i = 0; i < 4; i++) begin : g_lvl
      // R8
      filt_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (filt_lvl[i] != $past(filt_lvl[i])) |-> (filt_lvl[i] == $past(sync_lvl[i])));
   end
endmodule

bind quad_pulse_counter qpc_checker #(.CNT_W(CNT_W)) u_qpc_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .mode_q   (mode_q),
   .hold_q   (hold_q),
   .zero_q   (zero_q),
   .count_q  (count_q),
   .sync_lvl (sync_lvl),
   .filt_lvl (filt_lvl)
);

// File: tb/quad_pulse_counter_test.sv
module quad_pulse_counter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  pin_p = 2'b00;
   logic [1:0]  pin_c = 2'b00;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   quad_pulse_counter #(.CNT_W(6), .FLT_W(10), .SYNC_N(2)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pulse_in(pin_p), .ctrl_in(pin_c)
   );

   // {p0,c0,p1,c1} then expected count (8-bit signed); mode 0x2149
   localparam logic [11:0] VEC [13] = '{
      12'hC01, 12'h400, 12'h000, 12'h8FF, 12'h000, 12'h201, 12'h001,
      12'h301, 12'h101, 12'hF02, 12'hC02, 12'h602, 12'h801
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      addr = a;
      #1;
      v = int'($signed(rdata));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse0(input int w);
      @(negedge clk);
      pin_p[0] = 1'b1;
      idle(w);
      pin_p[0] = 1'b0;
      idle(14);
   endtask

   task automatic zero_count();
      wr(2'd1, 16'h0002);
      wr(2'd1, 16'h0000);
   endtask

   initial begin
      int v;
      idle(5);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(2'd0, v); chk("R1 mode", v, 0);
      rd(2'd1, v); chk("R1 ctrl", v, 0);
      rd(2'd2, v); chk("R1 thr", v, 0);
      rd(2'd3, v); chk("R1 count", v, 0);

      // R2 readback and ignored count write
      wr(2'd0, 16'h2149); rd(2'd0, v); chk("R2 mode", v, 16'h2149);
      wr(2'd2, 16'h03FF); rd(2'd2, v); chk("R2 thr", v, 16'h03FF);
      wr(2'd2, 16'h0000);
      wr(2'd1, 16'h0000); rd(2'd1, v); chk("R2 ctrl", v, 0);
      wr(2'd3, 16'h0005); rd(2'd3, v); chk("R2 count write ignored", v, 0);

      // R3 R4 R5 table walk
      for (int i = 0; i < 13; i++) begin
         @(negedge clk);
         pin_p[0] = VEC[i][11]; pin_c[0] = VEC[i][10];
         pin_p[1] = VEC[i][9];  pin_c[1] = VEC[i][8];
         idle(10);
         rd(2'd3, v);
         chk($sformatf("R3 R4 table step %0d", i), v, int'($signed(VEC[i][7:0])));
      end
      pin_p = 2'b00; pin_c = 2'b00;
      idle(10);
      zero_count();

      // R5 both channels in one clock
      wr(2'd0, 16'h0101);
      @(negedge clk); pin_p = 2'b11; idle(10);
      rd(2'd3, v); chk("R5 net +2", v, 2);
      wr(2'd0, 16'h0201);
      @(negedge clk); pin_p = 2'b00; idle(10);
      @(negedge clk); pin_p = 2'b11; idle(10);
      rd(2'd3, v); chk("R5 net 0", v, 2);
      pin_p = 2'b00; idle(10);

      // R3 reserved edge code
      wr(2'd0, 16'h0003); pulse0(2);
      rd(2'd3, v); chk("R3 code 3 no change", v, 2);
      // R4 control code 3 suppresses, low keeps
      wr(2'd0, 16'h0031);
      @(negedge clk); pin_c[0] = 1'b1; idle(10);
      pulse0(2);
      rd(2'd3, v); chk("R4 code 3 suppress", v, 2);
      @(negedge clk); pin_c[0] = 1'b0; idle(10);
      pulse0(2);
      rd(2'd3, v); chk("R4 low keep", v, 3);

      // R6 hold
      wr(2'd0, 16'h0001);
      wr(2'd1, 16'h0001);
      pulse0(2); pulse0(2);
      rd(2'd3, v); chk("R6 held", v, 3);
      wr(2'd1, 16'h0000);
      rd(2'd3, v); chk("R6 after release", v, 3);
      pulse0(2);
      rd(2'd3, v); chk("R6 resume", v, 4);

      // R7 zero
      wr(2'd1, 16'h0002); idle(2);
      rd(2'd3, v); chk("R7 zeroed", v, 0);
      pulse0(2);
      rd(2'd3, v); chk("R7 stays zero", v, 0);
      wr(2'd1, 16'h0000);
      pulse0(2);
      rd(2'd3, v); chk("R7 counts from zero", v, 1);

      // R8 filter
      zero_count();
      wr(2'd2, 16'd5);
      wr(2'd1, 16'h0004);
      pulse0(4);
      rd(2'd3, v); chk("R8 short pulse rejected", v, 0);
      pulse0(5);
      rd(2'd3, v); chk("R8 threshold pulse passes", v, 1);
      wr(2'd1, 16'h0000);
      pulse0(1);
      rd(2'd3, v); chk("R8 filter off passes 1 cycle", v, 2);

      // R9 wrap
      zero_count();
      for (int k = 0; k < 31; k++) pulse0(2);
      rd(2'd3, v); chk("R9 top value", v, 31);
      pulse0(2);
      rd(2'd3, v); chk("R9 wrap to min", v, -32);
      rd(2'd3, v); chk("R9 sign extended", int'(rdata), 16'hFFE0);
      wr(2'd0, 16'h0002);
      pulse0(2);
      rd(2'd3, v); chk("R9 wrap to max", v, 31);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule